// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block is the general register file of a small processor with several privilege modes. Sixteen live registers serve the datapath through two combinational read ports and one clocked write port, and a saved-status register has its own read and write port. Some modes keep private copies of certain registers, and this block holds those copies next to the live ones.

When the core asks for a mode change, it gives the outgoing and incoming mode codes. In that clock edge the block stores the live stack pointer (r13), link register (r14) and saved status into the outgoing mode's bank, and loads them from the incoming mode's bank. The fast-interrupt mode also has its own copies of r8 to r12. These are swapped only when that mode is entered or left, and separately from the per-mode bank. User and system mode share one bank. A request that names an undefined mode code raises a one-cycle error pulse and leaves the mode and all banked state unchanged.

Top module: `regbank_core`

## Requirements
- R1: While `rst` is high on a clock edge, all live registers, all bank copies and the saved status are cleared to zero, `cur_mode` becomes 0x13 (supervisor) and `mode_err` becomes 0.
- R2: `rd_data_a` and `rd_data_b` show the live register selected by `rd_addr_a` and `rd_addr_b` without a clock. A write with `wr_en` high is visible from the cycle after the edge. The same holds for `spsr_wr_en` and `spsr_rd_data`.
- R3: The defined 5-bit mode codes are 0x10 user, 0x11 fast interrupt, 0x12 interrupt, 0x13 supervisor, 0x17 abort, 0x1B undefined and 0x1F system. User and system use the same bank, so a change between them leaves r13, r14 and the saved status as they were.
- R4: On a valid request, r13, r14 and the saved status are stored into the bank of `mode_old`. They are then reloaded from the bank of `mode_new`, and reads in the next cycle show the reloaded values.
- R5: On a valid request that leaves fast-interrupt mode (old 0x11, new not 0x11), r8 to r12 are saved into the fast-interrupt copies and the user copies are restored.
- R6: On a valid request that enters fast-interrupt mode (new 0x11, old not 0x11), r8 to r12 are saved into the user copies and the fast-interrupt copies are loaded. A request from 0x11 to 0x11 leaves r8 to r12 unchanged.
- R7: A mode change never alters r0 to r7 or r15, and it alters r8 to r12 only in the cases of R5 and R6.
- R8: If `mode_old` or `mode_new` is not a defined code, `mode_err` is high for exactly the cycle after the request. `cur_mode`, r8 to r14 and the saved status then stay unchanged, apart from a write made in the same cycle.
- R9: A register or saved-status write in the same cycle as a valid mode change takes effect first, so a written r13, r14, r8 to r12 or saved status is banked under the outgoing mode.
- R10: After a valid request, `cur_mode` equals `mode_new` from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_addr_a | input | 4 | Read port A register index |
| rd_data_a | output | 32 | Read port A data |
| rd_addr_b | input | 4 | Read port B register index |
| rd_data_b | output | 32 | Read port B data |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 4 | Register write index |
| wr_data | input | 32 | Register write data |
| spsr_wr_en | input | 1 | Saved-status write enable |
| spsr_wr_data | input | 32 | Saved-status write data |
| spsr_rd_data | output | 32 | Live saved-status value |
| mode_req | input | 1 | Mode-change request |
| mode_old | input | 5 | Code of the mode being left |
| mode_new | input | 5 | Code of the mode being entered |
| cur_mode | output | 5 | Mode code after the last valid change |
| mode_err | output | 1 | One-cycle pulse after a request with an undefined code |

## Verification
A register write and a mode swap can land on the same clock edge. The bench provokes this by writing r13, r14, one of r8 to r12 and the saved status in the same cycle as a change, including changes into and out of fast-interrupt mode. Afterwards it returns to the outgoing mode and checks that the written values come back from that mode's bank, while the incoming mode shows its own stored copies. A write that coincides with a rejected request is also checked: it must land in the live register, and the banks must stay untouched.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

    localparam int NUM_BANKS  = 6;
    localparam int BANK_IDX_W = 3;
    localparam int MODE_W     = 5;
    localparam int HI_FIRST   = 8;
    localparam int HI_COUNT   = 5;
    localparam int SP_IDX     = 13;
    localparam int LR_IDX     = 14;

    typedef enum logic [MODE_W-1:0] {
        MODE_USER  = 5'h10,
        MODE_FAST  = 5'h11,
        MODE_INTR  = 5'h12,
        MODE_SUPV  = 5'h13,
        MODE_ABRT  = 5'h17,
        MODE_UNDEF = 5'h1B,
        MODE_SYST  = 5'h1F
    } mode_e;

    typedef struct packed {
        logic                  valid;
        logic                  is_fast;
        logic [BANK_IDX_W-1:0] bank;
    } mode_info_t;

    function automatic mode_info_t decode_mode(input logic [MODE_W-1:0] code);
        mode_info_t info;
        info = '{valid: 1'b1, is_fast: 1'b0, bank: '0};
        case (code)
            MODE_USER, MODE_SYST: info.bank = 3'd0;
            MODE_SUPV:            info.bank = 3'd1;
            MODE_ABRT:            info.bank = 3'd2;
            MODE_UNDEF:           info.bank = 3'd3;
            MODE_INTR:            info.bank = 3'd4;
            MODE_FAST: begin
                info.bank    = 3'd5;
                info.is_fast = 1'b1;
            end
            default:              info.valid = 1'b0;
        endcase
        return info;
    endfunction

endpackage

// File: rtl/regbank_mode_dec.sv
module regbank_mode_dec
    import regbank_pkg::*;
(
    input  logic [MODE_W-1:0] code,
    output mode_info_t        info
);
    always_comb info = decode_mode(code);
endmodule

// File: rtl/regbank_read_port.sv
module regbank_read_port #(
    parameter int DATA_W   = 32,
    parameter int NUM_REGS = 16,
    localparam int ADDR_W  = $clog2(NUM_REGS)
) (
    input  logic [NUM_REGS-1:0][DATA_W-1:0] regs,
    input  logic [ADDR_W-1:0]               addr,
    output logic [DATA_W-1:0]               data
);
    always_comb data = regs[addr];
endmodule

// File: rtl/regbank_core.sv
module regbank_core
    import regbank_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int NUM_REGS = 16,
    localparam int ADDR_W  = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] rd_addr_a,
    output logic [DATA_W-1:0] rd_data_a,
    input  logic [ADDR_W-1:0] rd_addr_b,
    output logic [DATA_W-1:0] rd_data_b,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              spsr_wr_en,
    input  logic [DATA_W-1:0] spsr_wr_data,
    output logic [DATA_W-1:0] spsr_rd_data,
    input  logic              mode_req,
    input  logic [4:0]        mode_old,
    input  logic [4:0]        mode_new,
    output logic [4:0]        cur_mode,
    output logic              mode_err
);
    localparam int NUM_PORTS = 2;

    // live state
    logic [NUM_REGS-1:0][DATA_W-1:0]  live_q;
    logic [DATA_W-1:0]                spsr_q;
    // banked copies
    logic [NUM_BANKS-1:0][DATA_W-1:0] bank_sp_q, bank_lr_q, bank_ss_q;
    logic [HI_COUNT-1:0][DATA_W-1:0]  user_hi_q, fast_hi_q;
    logic [MODE_W-1:0]                mode_q;
    logic                             err_q;

    // write-first view of live state
    logic [NUM_REGS-1:0][DATA_W-1:0]  live_w;
    logic [DATA_W-1:0]                spsr_w;

    mode_info_t info_old, info_new;
    logic       swap_go, fast_leave, fast_enter, same_bank;

    regbank_mode_dec u_dec_old (.code(mode_old), .info(info_old));
    regbank_mode_dec u_dec_new (.code(mode_new), .info(info_new));

    logic [NUM_PORTS-1:0][ADDR_W-1:0] rd_addr;
    logic [NUM_PORTS-1:0][DATA_W-1:0] rd_data;
    assign rd_addr[0] = rd_addr_a;
    assign rd_addr[1] = rd_addr_b;
    assign rd_data_a  = rd_data[0];
    assign rd_data_b  = rd_data[1];

    generate
        for (genvar p = 0; p < NUM_PORTS; p++) begin : g_rd
            regbank_read_port #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_port (
                .regs (live_q),
                .addr (rd_addr[p]),
                .data (rd_data[p])
            );
        end
    endgenerate

    always_comb begin
        live_w = live_q;
        if (wr_en) live_w[wr_addr] = wr_data;
        spsr_w = spsr_en_mux(spsr_wr_en, spsr_wr_data, spsr_q);
    end

    function automatic logic [DATA_W-1:0] spsr_en_mux(input logic en,
                                                      input logic [DATA_W-1:0] d,
                                                      input logic [DATA_W-1:0] q);
        return en ? d : q;
    endfunction

    assign swap_go    = mode_req && info_old.valid && info_new.valid;
    assign fast_leave = swap_go && info_old.is_fast && !info_new.is_fast;
    assign fast_enter = swap_go && info_new.is_fast && !info_old.is_fast;
    assign same_bank  = (info_old.bank == info_new.bank);

    // values loaded into r13, r14 and saved status on a swap
    logic [DATA_W-1:0] sp_load, lr_load, ss_load;
    always_comb begin
        sp_load = same_bank ? live_w[SP_IDX] : bank_sp_q[info_new.bank];
        lr_load = same_bank ? live_w[LR_IDX] : bank_lr_q[info_new.bank];
        ss_load = same_bank ? spsr_w         : bank_ss_q[info_new.bank];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            live_q    <= '0;
            spsr_q    <= '0;
            bank_sp_q <= '0;
            bank_lr_q <= '0;
            bank_ss_q <= '0;
            user_hi_q <= '0;
            fast_hi_q <= '0;
            mode_q    <= MODE_SUPV;
            err_q     <= 1'b0;
        end else begin
            err_q  <= mode_req && !(info_old.valid && info_new.valid);
            live_q <= live_w;
            spsr_q <= spsr_w;
            if (swap_go) begin
                mode_q                     <= mode_new;
                bank_sp_q[info_old.bank]   <= live_w[SP_IDX];
                bank_lr_q[info_old.bank]   <= live_w[LR_IDX];
                bank_ss_q[info_old.bank]   <= spsr_w;
                live_q[SP_IDX]             <= sp_load;
                live_q[LR_IDX]             <= lr_load;
                spsr_q                     <= ss_load;
                for (int k = 0; k < HI_COUNT; k++) begin
                    if (fast_leave) begin
                        fast_hi_q[k]          <= live_w[HI_FIRST+k];
                        live_q[HI_FIRST+k]    <= user_hi_q[k];
                    end else if (fast_enter) begin
                        user_hi_q[k]          <= live_w[HI_FIRST+k];
                        live_q[HI_FIRST+k]    <= fast_hi_q[k];
                    end
                end
            end
        end
    end

    assign spsr_rd_data = spsr_q;
    assign cur_mode     = mode_q;
    assign mode_err     = err_q;

endmodule

// File: rtl/regbank_checker.sv
module regbank_checker (
    input logic        clk,
    input logic        rst,
    input logic        mode_req,
    input logic [4:0]  mode_old,
    input logic [4:0]  mode_new,
    input logic        spsr_wr_en,
    input logic [31:0] spsr_rd_data,
    input logic [4:0]  cur_mode,
    input logic        mode_err
);
    logic old_ok, new_ok;
    assign old_ok = mode_old inside {5'h10, 5'h11, 5'h12, 5'h13, 5'h17, 5'h1B, 5'h1F};
    assign new_ok = mode_new inside {5'h10, 5'h11, 5'h12, 5'h13, 5'h17, 5'h1B, 5'h1F};

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (cur_mode == 5'h13 && !mode_err && spsr_rd_data == '0));

    assert_bad_code_flags_R8: assert property (@(posedge clk) disable iff (rst)
        (mode_req && !(old_ok && new_ok)) |=> (mode_err && $stable(cur_mode)));

    assert_bad_code_keeps_status_R8: assert property (@(posedge clk) disable iff (rst)
        (mode_req && !(old_ok && new_ok) && !spsr_wr_en) |=> $stable(spsr_rd_data));

    assert_no_spurious_error_R8: assert property (@(posedge clk) disable iff (rst)
        !mode_req |=> !mode_err);

    assert_mode_follows_R10: assert property (@(posedge clk) disable iff (rst)
        (mode_req && old_ok && new_ok) |=> (cur_mode == $past(mode_new)));

    assert_mode_holds_R10: assert property (@(posedge clk) disable iff (rst)
        !mode_req |=> $stable(cur_mode));

    assert_code_defined_R3: assert property (@(posedge clk) disable iff (rst)
        cur_mode inside {5'h10, 5'h11, 5'h12, 5'h13, 5'h17, 5'h1B, 5'h1F});
endmodule

bind regbank_core regbank_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .mode_req     (mode_req),
    .mode_old     (mode_old),
    .mode_new     (mode_new),
    .spsr_wr_en   (spsr_wr_en),
    .spsr_rd_data (spsr_rd_data),
    .cur_mode     (cur_mode),
    .mode_err     (mode_err)
);

// File: tb/regbank_core_tb.sv
`timescale 1ns/1ps
module regbank_core_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  rd_addr_a = '0, rd_addr_b = '0, wr_addr = '0;
    logic [31:0] rd_data_a, rd_data_b, wr_data = '0, spsr_wr_data = '0, spsr_rd_data;
    logic        wr_en = 1'b0, spsr_wr_en = 1'b0, mode_req = 1'b0;
    logic [4:0]  mode_old = '0, mode_new = '0, cur_mode;
    logic        mode_err;

    always #4 clk = ~clk;

    regbank_core u_dut (
        .clk(clk), .rst(rst),
        .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
        .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .spsr_wr_en(spsr_wr_en), .spsr_wr_data(spsr_wr_data), .spsr_rd_data(spsr_rd_data),
        .mode_req(mode_req), .mode_old(mode_old), .mode_new(mode_new),
        .cur_mode(cur_mode), .mode_err(mode_err)
    );

    int n_checks = 0, n_fail = 0;
    bit done = 0;

    // reference model
    logic [31:0] m_live [16];
    logic [31:0] m_user_hi [5], m_fast_hi [5];
    logic [31:0] m_sp [6], m_lr [6], m_ss [6];
    logic [31:0] m_spsr;
    logic [4:0]  m_mode;
    logic        m_err;

    logic [4:0] codes [7] = '{5'h10, 5'h11, 5'h12, 5'h13, 5'h17, 5'h1B, 5'h1F};

    function automatic int bank_of(input logic [4:0] c);
        case (c)
            5'h10, 5'h1F: return 0;
            5'h13: return 1;
            5'h17: return 2;
            5'h1B: return 3;
            5'h12: return 4;
            5'h11: return 5;
            default: return -1;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 16; i++) m_live[i] = '0;
        for (int i = 0; i < 5; i++) begin m_user_hi[i] = '0; m_fast_hi[i] = '0; end
        for (int i = 0; i < 6; i++) begin m_sp[i] = '0; m_lr[i] = '0; m_ss[i] = '0; end
        m_spsr = '0; m_mode = 5'h13; m_err = 1'b0;
    endtask

    // one clock: drive at negedge, model update, sample after edge
    task automatic step(input bit req, input logic [4:0] mo, input logic [4:0] mn,
                        input bit we, input logic [3:0] wa, input logic [31:0] wd,
                        input bit swe, input logic [31:0] swd);
        int bo, bn;
        @(negedge clk);
        mode_req = req; mode_old = mo; mode_new = mn;
        wr_en = we; wr_addr = wa; wr_data = wd;
        spsr_wr_en = swe; spsr_wr_data = swd;
        if (we) m_live[wa] = wd;
        if (swe) m_spsr = swd;
        bo = bank_of(mo); bn = bank_of(mn);
        m_err = req && (bo < 0 || bn < 0);
        if (req && bo >= 0 && bn >= 0) begin
            m_sp[bo] = m_live[13]; m_lr[bo] = m_live[14]; m_ss[bo] = m_spsr;
            m_live[13] = m_sp[bn]; m_live[14] = m_lr[bn]; m_spsr = m_ss[bn];
            if (mo == 5'h11 && mn != 5'h11) begin
                for (int i = 0; i < 5; i++) begin
                    m_fast_hi[i] = m_live[8+i]; m_live[8+i] = m_user_hi[i];
                end
            end else if (mn == 5'h11 && mo != 5'h11) begin
                for (int i = 0; i < 5; i++) begin
                    m_user_hi[i] = m_live[8+i]; m_live[8+i] = m_fast_hi[i];
                end
            end
            m_mode = mn;
        end
        @(posedge clk);
        #1;
        mode_req = 1'b0; wr_en = 1'b0; spsr_wr_en = 1'b0;
    endtask

    task automatic check_all(input string tag);
        for (int i = 0; i < 16; i++) begin
            rd_addr_a = 4'(i); rd_addr_b = 4'(15 - i);
            #0.1;
            check($sformatf("%s r%0d port a", tag, i), rd_data_a, m_live[i]);
            check($sformatf("%s r%0d port b", tag, 15 - i), rd_data_b, m_live[15 - i]);
        end
        check({tag, " saved status"}, spsr_rd_data, m_spsr);
        check({tag, " R10 mode"}, 32'(cur_mode), 32'(m_mode));
        check({tag, " R8 error flag"}, 32'(mode_err), 32'(m_err));
    endtask

    task automatic change(input logic [4:0] to);
        step(1'b1, m_mode, to, 1'b0, '0, '0, 1'b0, '0);
    endtask

    initial begin
        #(8.0 * 200000);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        // R1 reset state
        check_all("R1 reset");

        // R2 write/read on every register
        for (int i = 0; i < 16; i++)
            step(1'b0, '0, '0, 1'b1, 4'(i), 32'h1000_0000 + 32'(i * 3), 1'b0, '0);
        step(1'b0, '0, '0, 1'b0, '0, '0, 1'b1, 32'h5A5A_0001);
        check_all("R2 writes");

        // R3 R4 R5 R6 R7 sweep over all ordered mode pairs
        for (int a = 0; a < 7; a++) begin
            for (int b = 0; b < 7; b++) begin
                change(codes[a]);
                for (int i = 0; i < 16; i++)
                    step(1'b0, '0, '0, 1'b1, 4'(i), {8'(a), 8'(b), 8'(i), 8'hC3}, 1'b0, '0);
                step(1'b0, '0, '0, 1'b0, '0, '0, 1'b1, {8'(a), 8'(b), 16'h55AA});
                change(codes[b]);
                check_all($sformatf("R4 R5 R6 R7 swap %h->%h", codes[a], codes[b]));
            end
        end

        // R3 user and system share one bank
        change(5'h10);
        step(1'b0, '0, '0, 1'b1, 4'd13, 32'hAAAA_1313, 1'b0, '0);
        change(5'h1F);
        rd_addr_a = 4'd13; #0.1;
        check("R3 shared user/system r13", rd_data_a, 32'hAAAA_1313);
        check_all("R3 user to system");

        // R9 write coinciding with change, including fast-mode entry
        change(5'h13);
        step(1'b1, 5'h13, 5'h11, 1'b1, 4'd13, 32'hDEAD_0013, 1'b1, 32'hBEEF_0001);
        check_all("R9 write+enter fast r13");
        step(1'b1, 5'h11, 5'h13, 1'b1, 4'd10, 32'hFA57_000A, 1'b0, '0);
        check_all("R9 write+leave fast r10");
        rd_addr_a = 4'd13; #0.1;
        check("R9 supervisor r13 banked write", rd_data_a, 32'hDEAD_0013);
        check("R9 saved status banked write", spsr_rd_data, 32'hBEEF_0001);
        step(1'b1, 5'h13, 5'h11, 1'b1, 4'd14, 32'h1234_0014, 1'b0, '0);
        step(1'b1, 5'h11, 5'h13, 1'b0, '0, '0, 1'b0, '0);
        check_all("R9 r14 return");
        rd_addr_a = 4'd14; #0.1;
        check("R9 r14 written before swap", rd_data_a, 32'h1234_0014);
        step(1'b1, 5'h13, 5'h11, 1'b0, '0, '0, 1'b0, '0);
        rd_addr_a = 4'd10; #0.1;
        check("R9 fast copy of r10", rd_data_a, 32'hFA57_000A);
        check_all("R6 fast copies");
        step(1'b1, 5'h11, 5'h11, 1'b1, 4'd9, 32'h0909_0909, 1'b0, '0);
        check_all("R6 fast to fast");

        // R8 every undefined new code, and undefined old codes
        for (int c = 0; c < 32; c++) begin
            if (bank_of(5'(c)) < 0) begin
                step(1'b1, m_mode, 5'(c), 1'b1, 4'd2, 32'hE000_0000 + 32'(c), 1'b0, '0);
                check_all($sformatf("R8 bad new %h", c));
                step(1'b1, 5'(c), 5'h12, 1'b0, '0, '0, 1'b0, '0);
                check_all($sformatf("R8 bad old %h", c));
                step(1'b0, '0, '0, 1'b0, '0, '0, 1'b0, '0);
                check_all("R8 error cleared");
            end
        end

        // R1 reset mid-run
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1; rst = 1'b0;
        model_reset();
        check_all("R1 second reset");

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule